// File: doc/BRIEF.md
# Toggle-Write Interrupt Status and Enable Bank

This block gathers up to 32 interrupt sources from core logic into a status register and masks them with an enable register. Both registers sit behind a small 32-bit memory-mapped read/write port. A one-cycle pulse on a source input latches its status bit. The single interrupt output rises when any latched bit is also enabled.

Software uses one write operation both to raise and to acknowledge interrupts. Writing a 1 to a status bit flips it, and writing a 0 leaves it alone. The same path therefore injects test interrupts and clears serviced ones.

The number of sources is a parameter. Implemented bits fill the word from bit 31 downward. A second parameter sets the reset value of each status bit, so a source may come out of reset already pending.

Top module: `irq_toggle_bank`

## Requirements
- R1: With `NUM_SRC` = N (0 to 32), only bits 31 down to 32-N exist in both registers. Lower bits always read 0, and writes and source pulses on those positions have no effect. With N = 0, every read returns 0 and `irq_o` stays low.
- R2: Reset (`rst_n` low, asynchronous) has three effects. The enable register becomes all zeros. Each implemented status bit takes the matching bit of `STAT_RST`. `irq_o` and `bus_rdata` become 0.
- R3: A bus write to offset 0x0 flips every implemented status bit whose `bus_wdata` bit is 1 and leaves bits written with 0 unchanged. The result is visible from the next clock edge.
- R4: An implemented status bit whose `evt_i` bit is high during a clock edge is 1 after that edge. It stays 1 until software flips it or reset occurs. Without a status write or an event, status holds its value.
- R5: When a source event and a status write with a 1 hit the same bit in the same cycle, the bit ends up 1, whatever its previous value.
- R6: A bus write to offset 0x4 loads the enable register with `bus_wdata` masked to the implemented bits. Writing 0 disables every source.
- R7: `irq_o` is registered. After edge k+1 it equals the OR over all bits of (status AND enable) as they stood after edge k, so it follows a qualifying change one cycle later.
- R8: Offset 0x0 holds status and offset 0x4 holds enable, compared on all `ADDR_W` address bits. A write to any other offset changes nothing, and a read of any other offset returns 0.
- R9: A read (`bus_valid` high, `bus_write` low) places the addressed register's value, as it stood before that edge, on `bus_rdata` after the edge. `bus_rdata` then holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| evt_i | input | 32 | Source events, bit i for status bit i |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A corrupted status or enable bit appears on `bus_rdata` one cycle after the next read of that register. If the bit is enabled, it also appears on `irq_o` one cycle after the corruption, as a spurious or missing request. A wrong priority between an event and a toggle leaves a pending bit cleared, which the next status read shows as a 0. A decode fault lets writes to unmapped or lower bit positions leak into the registers, and readback of both registers exposes that leak at once. The bench sweeps every status and enable pattern of a four-source instance. It also runs a zero-source instance beside it, which must read all zeros.

// File: rtl/irq_bank_pkg.sv
`timescale 1ns/1ps
package irq_bank_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_ENAB = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] enab;
        logic [WORD_W-1:0] rdata;
        logic              irq;
    } bank_regs_t;

    // Bits 31 .. WORD_W-n are implemented.
    function automatic logic [WORD_W-1:0] impl_mask(input int n);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (i >= WORD_W - n) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/irq_addr_decode.sv
`timescale 1ns/1ps
module irq_addr_decode
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int STAT_OFS = 0,
    parameter int ENAB_OFS = 4
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic              wr,
    output logic              rd
);
    always_comb begin
        if (addr == ADDR_W'(STAT_OFS))      sel = SEL_STAT;
        else if (addr == ADDR_W'(ENAB_OFS)) sel = SEL_ENAB;
        else                                sel = SEL_NONE;
        wr = valid &&  write;
        rd = valid && !write;
    end
endmodule

// File: rtl/irq_status_cell.sv
`timescale 1ns/1ps
module irq_status_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic tog,
    output logic stat_q
);
    logic stat_d;

    // Event has priority over a same-cycle toggle.
    always_comb begin
        stat_d = evt | (stat_q ^ tog);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= RST_VAL;
        else        stat_q <= stat_d;
    end
endmodule

// File: rtl/irq_any_reduce.sv
`timescale 1ns/1ps
module irq_any_reduce #(
    parameter int W = 32
) (
    input  logic [W-1:0] stat,
    input  logic [W-1:0] enab,
    output logic         any
);
    always_comb begin
        any = |(stat & enab);
    end
endmodule

// File: rtl/irq_toggle_bank.sv
`timescale 1ns/1ps
module irq_toggle_bank
    import irq_bank_pkg::*;
#(
    parameter int          NUM_SRC  = 8,
    parameter logic [31:0] STAT_RST = 32'h0000_0000,
    parameter int          ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       evt_i,
    output logic              irq_o
);
    localparam logic [WORD_W-1:0] IMPL      = impl_mask(NUM_SRC);
    localparam logic [WORD_W-1:0] STAT_INIT = STAT_RST & IMPL;
    localparam int                LOW_BIT   = WORD_W - NUM_SRC;

    reg_sel_e          sel;
    logic              wr, rd;
    logic [WORD_W-1:0] tog_vec, evt_vec, status_q, enab_q;
    logic              any_set;
    bank_regs_t        regs_d, regs_q;

    irq_addr_decode #(.ADDR_W(ADDR_W), .STAT_OFS(0), .ENAB_OFS(4)) u_dec (
        .valid (bus_valid),
        .write (bus_write),
        .addr  (bus_addr),
        .sel   (sel),
        .wr    (wr),
        .rd    (rd)
    );

    always_comb begin
        tog_vec = (wr && sel == SEL_STAT) ? (bus_wdata & IMPL) : '0;
        evt_vec = evt_i & IMPL;
    end

    for (genvar g = 0; g < WORD_W; g++) begin : g_bit
        if (g >= LOW_BIT) begin : g_impl
            irq_status_cell #(.RST_VAL(STAT_INIT[g])) u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .evt    (evt_vec[g]),
                .tog    (tog_vec[g]),
                .stat_q (status_q[g])
            );
        end else begin : g_absent
            assign status_q[g] = 1'b0;
        end
    end

    assign enab_q = regs_q.enab;

    irq_any_reduce #(.W(WORD_W)) u_any (
        .stat (status_q),
        .enab (enab_q),
        .any  (any_set)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr && sel == SEL_ENAB) regs_d.enab = bus_wdata & IMPL;
        if (rd) begin
            case (sel)
                SEL_STAT: regs_d.rdata = status_q;
                SEL_ENAB: regs_d.rdata = regs_q.enab;
                default:  regs_d.rdata = '0;
            endcase
        end
        regs_d.irq = any_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{enab: '0, rdata: '0, irq: 1'b0};
        else        regs_q <= regs_d;
    end

    assign bus_rdata = regs_q.rdata;
    assign irq_o     = regs_q.irq;
endmodule

// File: rtl/irq_bank_chk.sv
`timescale 1ns/1ps
module irq_bank_chk #(
    parameter int NUM_SRC = 8,
    parameter int ADDR_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [31:0]       evt_i,
    input logic              irq_o,
    input logic [31:0]       status_q,
    input logic [31:0]       enab_q
);
    localparam logic [31:0] IMPL = irq_bank_pkg::impl_mask(NUM_SRC);

    logic wr_stat, wr_enab, rd_stat, rd_other, no_evt;
    always_comb begin
        wr_stat  = bus_valid &&  bus_write && bus_addr == ADDR_W'(0);
        wr_enab  = bus_valid &&  bus_write && bus_addr == ADDR_W'(4);
        rd_stat  = bus_valid && !bus_write && bus_addr == ADDR_W'(0);
        rd_other = bus_valid && !bus_write && bus_addr != ADDR_W'(0)
                   && bus_addr != ADDR_W'(4);
        no_evt   = (evt_i & IMPL) == 32'h0;
    end

    // R1
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q | enab_q | bus_rdata) & ~IMPL) == 32'h0);

    // R3
    toggle_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat && no_evt |=> status_q == ($past(status_q) ^ ($past(bus_wdata) & IMPL)));

    // R4
    event_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !no_evt |=> (status_q & $past(evt_i & IMPL)) == $past(evt_i & IMPL));

    // R4
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat && no_evt |=> $stable(status_q));

    // R5
    collide_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat && ((evt_i & bus_wdata & IMPL) != 32'h0)
        |=> (status_q & $past(evt_i & bus_wdata & IMPL)) == $past(evt_i & bus_wdata & IMPL));

    // R6
    enab_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_enab |=> enab_q == ($past(bus_wdata) & IMPL));

    // R7
    irq_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_o == $past(|(status_q & enab_q)));

    // R9
    read_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> bus_rdata == $past(status_q));

    // R8
    read_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_other |=> bus_rdata == 32'h0);
endmodule

bind irq_toggle_bank irq_bank_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_irq_bank_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_i     (evt_i),
    .irq_o     (irq_o),
    .status_q  (status_q),
    .enab_q    (enab_q)
);

// File: tb/test_irq_toggle_bank.sv
`timescale 1ns/1ps
module test_irq_toggle_bank;
    localparam int          N     = 4;
    localparam logic [31:0] SRST  = 32'h4000_0000;
    localparam logic [31:0] M     = 32'hF000_0000;
    localparam logic [31:0] JUNK  = 32'h0A5C_3E91;
    localparam int          AW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0, bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0, evt_i = '0;
    logic [31:0]   rdata, rdata_z;
    logic          irq, irq_z;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [31:0] s_exp, e_exp, rv, rz;

    always #2 clk = ~clk;

    irq_toggle_bank #(.NUM_SRC(N), .STAT_RST(SRST), .ADDR_W(AW)) i_irq_toggle_bank (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata),
        .evt_i(evt_i), .irq_o(irq));

    irq_toggle_bank #(.NUM_SRC(0), .STAT_RST(32'hFFFF_FFFF), .ADDR_W(AW)) i_irq_toggle_bank_none (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_z),
        .evt_i(evt_i), .irq_o(irq_z));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] v, output logic [31:0] vz);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        v = rdata; vz = rdata_z;
    endtask

    task automatic pulse(input logic [31:0] ev);
        @(negedge clk);
        evt_i = ev;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog R7 actual=%08h expected=%08h", 0, 1);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state
        chk(irq == 1'b0, "R2 irq after reset", {31'b0, irq}, 0);
        rd(AW'(0), rv, rz);
        chk(rv == SRST, "R2 status reset value", rv, SRST);
        chk(rz == 0, "R1 zero-width status read", rz, 0);
        rd(AW'(4), rv, rz);
        chk(rv == 0, "R2 enable reset zero", rv, 0);
        s_exp = SRST; e_exp = 0;

        // R3 and R1: toggle sweep, lower junk bits ignored
        for (int v = 0; v < 16; v++) begin
            logic [31:0] wd;
            wd = (32'(v) << 28) | JUNK;
            s_exp ^= wd & M;
            wr(AW'(0), wd);
            rd(AW'(0), rv, rz);
            chk(rv == s_exp, "R3 toggle readback", rv, s_exp);
            chk(rz == 0, "R1 zero-width after toggle", rz, 0);
        end

        // R6 and R1: enable sweep
        for (int v = 0; v < 16; v++) begin
            logic [31:0] wd;
            wd = (32'(v) << 28) | JUNK;
            e_exp = wd & M;
            wr(AW'(4), wd);
            rd(AW'(4), rv, rz);
            chk(rv == e_exp, "R6 enable readback", rv, e_exp);
        end

        // R7: exhaustive status x enable
        for (int s = 0; s < 16; s++) begin
            for (int e = 0; e < 16; e++) begin
                logic [31:0] tgt;
                logic        want;
                tgt = 32'(s) << 28;
                wr(AW'(0), s_exp ^ tgt);
                s_exp = tgt;
                e_exp = 32'(e) << 28;
                wr(AW'(4), e_exp);
                @(negedge clk);
                want = |(s_exp & e_exp);
                chk(irq == want, "R7 irq level", {31'b0, irq}, {31'b0, want});
                chk(irq_z == 1'b0, "R1 zero-width irq", {31'b0, irq_z}, 0);
            end
        end

        // R6: writing 0 disables all
        wr(AW'(0), s_exp ^ M); s_exp = M;
        wr(AW'(4), 32'h0); e_exp = 0;
        @(negedge clk);
        chk(irq == 1'b0, "R6 enable zero masks all", {31'b0, irq}, 0);

        // R7: one-cycle latency
        wr(AW'(0), s_exp ^ 32'h1000_0000); s_exp = 32'h1000_0000;
        wr(AW'(4), 32'h1000_0000);
        chk(irq == 1'b0, "R7 irq not yet raised", {31'b0, irq}, 0);
        @(negedge clk);
        chk(irq == 1'b1, "R7 irq raised next cycle", {31'b0, irq}, 1);

        // R4: events latch and persist
        wr(AW'(0), s_exp); s_exp = 0;
        wr(AW'(4), 32'h0);
        for (int b = 28; b < 32; b++) begin
            pulse(32'h1 << b);
            s_exp |= 32'h1 << b;
            repeat (3) @(negedge clk);
            rd(AW'(0), rv, rz);
            chk(rv == s_exp, "R4 event latched and held", rv, s_exp);
        end
        pulse(32'h0FFF_FFFF);
        rd(AW'(0), rv, rz);
        chk(rv == s_exp, "R4 low-position events ignored", rv, s_exp);
        chk(rz == 0, "R1 zero-width ignores events", rz, 0);

        // R5: same-cycle event and toggle
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = AW'(0);
        bus_wdata = 32'h8000_0000; evt_i = 32'h8000_0000;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0; evt_i = '0;
        rd(AW'(0), rv, rz);
        chk(rv == s_exp, "R5 set bit stays set", rv, s_exp);
        wr(AW'(0), 32'h4000_0000); s_exp &= ~32'h4000_0000;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = AW'(0);
        bus_wdata = 32'h4000_0000; evt_i = 32'h4000_0000;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0; evt_i = '0;
        s_exp |= 32'h4000_0000;
        rd(AW'(0), rv, rz);
        chk(rv == s_exp, "R5 clear bit becomes set", rv, s_exp);

        // R8: unmapped offsets
        wr(AW'(4), 32'hA000_0000); e_exp = 32'hA000_0000;
        wr(AW'(8), 32'hFFFF_FFFF);
        wr(AW'(1), 32'hFFFF_FFFF);
        rd(AW'(0), rv, rz);
        chk(rv == s_exp, "R8 unmapped write leaves status", rv, s_exp);
        rd(AW'(4), rv, rz);
        chk(rv == e_exp, "R8 unmapped write leaves enable", rv, e_exp);
        rd(AW'(8), rv, rz);
        chk(rv == 0, "R8 unmapped read zero", rv, 0);
        rd(AW'(12), rv, rz);
        chk(rv == 0, "R8 unmapped read zero", rv, 0);

        // R9: read data holds between reads
        rd(AW'(0), rv, rz);
        wr(AW'(0), 32'h1000_0000); s_exp ^= 32'h1000_0000;
        repeat (2) @(negedge clk);
        chk(rdata == rv, "R9 rdata holds", rdata, rv);
        rd(AW'(0), rv, rz);
        chk(rv == s_exp, "R9 rdata updates on read", rv, s_exp);

        // R2: reset again mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk(irq == 1'b0, "R2 irq cleared by reset", {31'b0, irq}, 0);
        rd(AW'(0), rv, rz);
        chk(rv == SRST, "R2 status back to reset value", rv, SRST);
        rd(AW'(4), rv, rz);
        chk(rv == 0, "R2 enable cleared by reset", rv, 0);

        done = 1'b1;
        finish_run();
    end
endmodule